// File: doc/BRIEF.md
# Synthesizer Serial Programming Controller

This controller sits on the host side of a three-wire serial link (serial clock, serial data, latch enable) that programs a dual-channel frequency synthesizer. Every register write to the synthesizer is a 24-bit word. The controller sends it most-significant bit first as three bytes with no gap between them. Latch enable is held low for the whole word. It rises once after the final bit, and that rising edge commits the shifted word to the register that the word's two least-significant bits select.

When reset is released, the controller runs a fixed start-up sequence of four writes taken from parameters, in this order:
1. The reference-divider word for channel one.
2. The main-divider word for channel one.
3. The reference-divider word for channel two.
4. The main-divider word for channel two.

During this sequence the request port is held off. After the fourth write, `init_done` rises and the controller accepts single words from a valid/ready port, one word per handshake. A parameter sets the length of each half-period of the serial clock in system clocks, so the serial clock can be kept at or below 20 MHz. The default of 7 cycles per half-period gives 17.9 MHz from a 250 MHz system clock.

Top module: `synth_prog_ctrl`

## Requirements
- R1: While `rst_n` is low, `ser_le` is 1, `ser_clk` is 0, `req_ready` is 0 and `init_done` is 0.
- R2: After each release of reset, the first four words received by the target are `INIT_W0`, `INIT_W1`, `INIT_W2` and `INIT_W3`, in that order.
- R3: `req_ready` stays 0 until `init_done` is 1. `init_done` is still 0 when the fourth start-up word is latched, rises after that write completes, and then stays 1 until reset.
- R4: Each frame carries exactly 24 rising edges of `ser_clk`, with data taken most-significant bit first. The latched word equals the requested word bit for bit, including the two latch-select bits [1:0].
- R5: `ser_le` is 0 at every rising edge of `ser_clk`. It falls before the first bit of a frame.
- R6: `ser_le` rises only while `ser_clk` is low, after the last bit of the frame.
- R7: Each high phase of `ser_clk` lasts exactly `HALF_PER` system clocks.
- R8: `ser_data` does not change while `ser_clk` is high.
- R9: Between two frames, `ser_le` stays high for at least `2*HALF_PER` system clocks, which is one serial clock period.
- R10: `req_ready` is 0 while a frame is being shifted. A request presented while `req_ready` is 0 produces no frame.
- R11: Asserting reset in the middle of a frame abandons that frame. Releasing reset starts the four-word start-up sequence again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request holds a word to send |
| req_word | input | 24 | Word to send; bits [1:0] select the target register |
| req_ready | output | 1 | Controller can accept a word this cycle |
| init_done | output | 1 | Start-up sequence has completed |
| ser_clk | output | 1 | Serial clock; idles low |
| ser_data | output | 1 | Serial data; changes only while `ser_clk` is low |
| ser_le | output | 1 | Latch enable; low while a frame is shifted |

## Verification
Most internal faults in this block reach the target as a corrupt latched word. An off-by-one in the bit counter, a wrong shift direction or a bad start-up index each shows up within one frame, about 24 serial periods, as a wrong value or a wrong edge count at the rising edge of `ser_le`. A sequencer that loses its position appears as reordered or missing start-up words, or as `init_done` rising too early. A fault in the divider or framing shows up within one serial period as an edge that breaks the phase length, the data hold window or the ordering of `ser_le` against `ser_clk`.

// File: rtl/spc_pkg.sv
package spc_pkg;

    // Number of writes in the power-up sequence
    localparam int NUM_INIT = 4;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_LATCH = 2'd2,
        SH_HOLD  = 2'd3
    } sh_state_e;

endpackage

// File: rtl/spc_tick.sv
// Half-period tick generator for the serial clock.
module spc_tick #(
    parameter int HALF_PER = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF_PER < 2) ? 1 : $clog2(HALF_PER);
    localparam logic [CW-1:0] LAST = CW'(HALF_PER - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (!en)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spc_shifter.sv
// Frames one word: latch enable low, MSB-first shift on rising edges,
// latch enable high after the last bit, then a guard interval.
module spc_shifter
    import spc_pkg::*;
#(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              busy,
    output logic              done,
    output logic              sclk,
    output logic              sdata,
    output logic              le
);
    localparam int BW = $clog2(WORD_W);
    localparam logic [BW-1:0] LAST_BIT = BW'(WORD_W - 1);

    typedef struct packed {
        sh_state_e         state;
        logic [WORD_W-1:0] shreg;
        logic [BW-1:0]     bitcnt;
        logic              sclk;
        logic              le;
        logic              gap;
    } sh_t;

    sh_t d, q;

    always_comb begin
        d    = q;
        done = 1'b0;
        unique case (q.state)
            SH_IDLE: begin
                if (start) begin
                    d.shreg  = word;
                    d.bitcnt = '0;
                    d.sclk   = 1'b0;
                    d.le     = 1'b0;
                    d.state  = SH_SHIFT;
                end
            end
            SH_SHIFT: begin
                if (tick) begin
                    if (!q.sclk) begin
                        d.sclk = 1'b1;
                    end else begin
                        d.sclk = 1'b0;
                        if (q.bitcnt == LAST_BIT) begin
                            d.state = SH_LATCH;
                        end else begin
                            d.shreg  = {q.shreg[WORD_W-2:0], 1'b0};
                            d.bitcnt = q.bitcnt + 1'b1;
                        end
                    end
                end
            end
            SH_LATCH: begin
                if (tick) begin
                    d.le    = 1'b1;
                    d.gap   = 1'b0;
                    d.state = SH_HOLD;
                end
            end
            SH_HOLD: begin
                if (tick) begin
                    if (q.gap) begin
                        d.state = SH_IDLE;
                        done    = 1'b1;
                    end else begin
                        d.gap = 1'b1;
                    end
                end
            end
            default: d.state = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state  <= SH_IDLE;
            q.shreg  <= '0;
            q.bitcnt <= '0;
            q.sclk   <= 1'b0;
            q.le     <= 1'b1;
            q.gap    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy  = (q.state != SH_IDLE);
    assign sclk  = q.sclk;
    assign sdata = q.shreg[WORD_W-1];
    assign le    = q.le;
endmodule

// File: rtl/spc_boot.sv
// Power-up sequencer: issues the four parameter words in order.
module spc_boot
    import spc_pkg::*;
#(
    parameter int              WORD_W  = 24,
    parameter logic [WORD_W-1:0] INIT_W0 = '0,
    parameter logic [WORD_W-1:0] INIT_W1 = '0,
    parameter logic [WORD_W-1:0] INIT_W2 = '0,
    parameter logic [WORD_W-1:0] INIT_W3 = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sh_busy,
    input  logic              sh_done,
    output logic              start,
    output logic [WORD_W-1:0] word,
    output logic              init_done
);
    localparam int IW = $clog2(NUM_INIT + 1);
    localparam logic [IW-1:0] IDX_END = IW'(NUM_INIT);
    localparam logic [WORD_W-1:0] SEQ [NUM_INIT] = '{INIT_W0, INIT_W1, INIT_W2, INIT_W3};

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          pend;
    } boot_t;

    boot_t d, q;

    always_comb begin
        d     = q;
        start = 1'b0;
        if ((q.idx != IDX_END) && !q.pend && !sh_busy) begin
            start  = 1'b1;
            d.pend = 1'b1;
        end
        if (q.pend && sh_done) begin
            d.pend = 1'b0;
            d.idx  = q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.idx  <= '0;
            q.pend <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign word      = SEQ[q.idx[1:0]];
    assign init_done = (q.idx == IDX_END);
endmodule

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl #(
    parameter int              WORD_W   = 24,
    parameter int              HALF_PER = 7,
    parameter logic [WORD_W-1:0] INIT_W0  = 24'h1F4800,
    parameter logic [WORD_W-1:0] INIT_W1  = 24'h0A3C81,
    parameter logic [WORD_W-1:0] INIT_W2  = 24'h00C802,
    parameter logic [WORD_W-1:0] INIT_W3  = 24'h147A53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ready,
    output logic              init_done,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_le
);
    logic              tick, sh_busy, sh_done, sh_start;
    logic              boot_start;
    logic [WORD_W-1:0] boot_word, sh_word;

    spc_tick #(.HALF_PER(HALF_PER)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sh_busy),
        .tick  (tick)
    );

    spc_boot #(
        .WORD_W  (WORD_W),
        .INIT_W0 (INIT_W0),
        .INIT_W1 (INIT_W1),
        .INIT_W2 (INIT_W2),
        .INIT_W3 (INIT_W3)
    ) u_boot (
        .clk       (clk),
        .rst_n     (rst_n),
        .sh_busy   (sh_busy),
        .sh_done   (sh_done),
        .start     (boot_start),
        .word      (boot_word),
        .init_done (init_done)
    );

    always_comb begin
        req_ready = init_done && !sh_busy;
        sh_start  = boot_start || (req_valid && req_ready);
        sh_word   = init_done ? req_word : boot_word;
    end

    spc_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (sh_start),
        .word  (sh_word),
        .busy  (sh_busy),
        .done  (sh_done),
        .sclk  (ser_clk),
        .sdata (ser_data),
        .le    (ser_le)
    );
endmodule

// File: rtl/spc_chk.sv
module spc_chk #(
    parameter int HALF_PER = 7
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic init_done,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_le
);
    logic        sclk_r;
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_r  <= 1'b0;
            run_cnt <= '0;
        end else begin
            sclk_r  <= ser_clk;
            run_cnt <= (ser_clk != sclk_r) ? 16'd0 : run_cnt + 16'd1;
        end
    end

    // R8
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R5
    le_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> !ser_le);

    // R6
    le_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_le) |-> !ser_clk);

    // R10
    ready_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_le |-> !req_ready);

    // R3
    ready_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !req_ready);

    // R3
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R7
    high_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_r && !ser_clk) |-> (run_cnt == 16'(HALF_PER - 1)));
endmodule

bind synth_prog_ctrl spc_chk #(.HALF_PER(HALF_PER)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .init_done (init_done),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_le    (ser_le)
);

// File: tb/sim_synth_prog_ctrl.sv
`timescale 1ns/1ps
module sim_synth_prog_ctrl;
    localparam int          HALF = 7;
    localparam logic [23:0] W0 = 24'h1F4800;
    localparam logic [23:0] W1 = 24'h0A3C81;
    localparam logic [23:0] W2 = 24'h00C802;
    localparam logic [23:0] W3 = 24'h147A53;
    localparam logic [23:0] INIT [4] = '{W0, W1, W2, W3};
    localparam int NV = 6;
    // stimulus word -> expected latched word
    localparam logic [47:0] VEC [NV] = '{
        {24'hA5F0C3, 24'hA5F0C3},
        {24'h000001, 24'h000001},
        {24'h800002, 24'h800002},
        {24'hFFFFFF, 24'hFFFFFF},
        {24'h000000, 24'h000000},
        {24'h5A3C96, 24'h5A3C96}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_word = '0;
    logic        req_ready, init_done, ser_clk, ser_data, ser_le;

    int ntests = 0;
    int nfail  = 0;

    always #2 clk = ~clk;

    synth_prog_ctrl #(
        .WORD_W(24), .HALF_PER(HALF),
        .INIT_W0(W0), .INIT_W1(W1), .INIT_W2(W2), .INIT_W3(W3)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_ready(req_ready), .init_done(init_done),
        .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le)
    );

    // target model
    logic        armed = 1'b0;
    logic [23:0] m_sh = '0;
    int          m_bits = 0;
    int          le_err = 0;
    logic [23:0] cap_w [32];
    int          cap_n [32];
    int          ncap = 0;

    always @(posedge ser_clk) if (armed) begin
        m_sh = {m_sh[22:0], ser_data};
        m_bits++;
        if (ser_le !== 1'b0) le_err++;
    end
    always @(negedge ser_le) m_bits = 0;
    always @(posedge ser_le) if (armed && ncap < 32) begin
        cap_w[ncap] = m_sh;
        cap_n[ncap] = m_bits;
        ncap++;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_caps(input int n);
        while (ncap < n) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_word  = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_boot(input string tag);
        wait_caps(4);
        chk(init_done == 1'b0, "R3 init_done low at 4th latch", 32'(init_done), 0);
        for (int i = 0; i < 4; i++) begin
            chk(cap_w[i] == INIT[i], {tag, " start-up word order"}, 32'(cap_w[i]), 32'(INIT[i]));
            chk(cap_n[i] == 24, "R4 edges per start-up frame", cap_n[i], 24);
        end
        while (!init_done) @(negedge clk);
        chk(req_ready == 1'b1, "R3 ready after init", 32'(req_ready), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        ntests++;
        nfail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        int base, cnt;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ser_le == 1'b1 && ser_clk == 1'b0, "R1 idle lines in reset",
            {30'd0, ser_le, ser_clk}, 32'h2);
        chk(req_ready == 1'b0 && init_done == 1'b0, "R1 flags in reset",
            {30'd0, req_ready, init_done}, 0);
        armed = 1'b1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R3 ready low during start-up", 32'(req_ready), 0);
        check_boot("R2");

        // R4 table of words
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][47:24]);
            wait_caps(4 + i + 1);
            chk(cap_w[4+i] == VEC[i][23:0], "R4 latched word", 32'(cap_w[4+i]), 32'(VEC[i][23:0]));
            chk(cap_n[4+i] == 24, "R4 edges per frame", cap_n[4+i], 24);
        end

        // R7 high phase length
        base = ncap;
        send(24'h3C3C3C);
        while (!ser_clk) @(negedge clk);
        cnt = 0;
        while (ser_clk) begin cnt++; @(negedge clk); end
        chk(cnt == HALF, "R7 high phase cycles", cnt, HALF);
        wait_caps(base + 1);

        // R9 back-to-back frames
        base = ncap;
        fork
            begin send(24'h123457); send(24'hFEDCBA); end
            begin
                wait_caps(base + 1);
                cnt = 0;
                while (ser_le) begin cnt++; @(negedge clk); end
                chk(cnt >= 2 * HALF, "R9 latch high gap", cnt, 2 * HALF);
            end
        join
        wait_caps(base + 2);
        chk(cap_w[base] == 24'h123457 && cap_w[base+1] == 24'hFEDCBA,
            "R9 both words intact", 32'(cap_w[base+1]), 32'hFEDCBA);

        // R10 request while busy is dropped
        base = ncap;
        send(24'h0F0F0E);
        while (ser_le) @(negedge clk);
        chk(req_ready == 1'b0, "R10 ready low while shifting", 32'(req_ready), 0);
        req_valid = 1'b1;
        req_word  = 24'hBADBAD;
        @(negedge clk);
        req_valid = 1'b0;
        wait_caps(base + 1);
        repeat (60 * HALF) @(negedge clk);
        chk(ncap == base + 1, "R10 no extra frame", ncap - base, 1);
        chk(cap_w[base] == 24'h0F0F0E, "R10 shifted word", 32'(cap_w[base]), 32'h0F0F0E);

        // R11 reset mid-frame
        send(24'h777777);
        while (m_bits < 5) @(negedge clk);
        armed = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(ser_le == 1'b1 && init_done == 1'b0, "R11 reset abandons frame",
            {30'd0, ser_le, init_done}, 32'h2);
        ncap   = 0;
        m_bits = 0;
        armed  = 1'b1;
        rst_n  = 1'b1;
        check_boot("R11");

        // R5 latch enable low at every rising serial edge
        chk(le_err == 0, "R5 rising edge with latch high", le_err, 0);

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule